// File: doc/BRIEF.md
# Registered Parallel-Prefix Adder

This block adds two unsigned W-bit operands (W = 128 by default) and returns a W-bit sum with a carry-out. It does not use the `+` operator. Each bit first forms a propagate term (XOR of the operand bits) and a generate term (AND of the operand bits). A grid of log2(W) prefix levels then turns these terms into group generates. Each group generate is the carry into the next bit position. The sum is the per-bit propagate XOR the carry from the bit below it. The carry-in is fixed at zero.

A build-time parameter selects the topology of the prefix grid:

- **Sparse tree.** A column combines at level j only where bit j of its index is set. Its partner is the last column of the preceding 2^j-aligned group. This tree has the fewest cells, but the fan-out doubles at each level and reaches W/2.
- **Dense tree.** Every column at or above 2^j combines with the column 2^j below it. The fan-out stays at 2, at the cost of more cells.

Each cell produces G = G_hi | (P_hi & G_lo) and P = P_hi & P_lo. Cells on the last level produce G only.

The operands are captured in an input register and the results leave from an output register. Parameters insert zero to two extra register stages on each side, so that the flow can retime logic into them. Reset is asynchronous and active low. The block releases it internally through a two-flop synchronizer.

Top module: `ppa_adder`

## Requirements
- R1: `sum_o` equals (A + B) mod 2^W for every operand pair. Examples: the half pattern (low W/2 bits set) plus its complement gives all ones, and repeated 0xA nibbles plus repeated 0x5 nibbles gives all ones.
- R2: `carry_o` is 1 exactly when A + B ≥ 2^W. Example: all ones plus 1 gives sum 0 with carry 1.
- R3: The carry out of each bit i equals g[i] | (p[i] & carry out of bit i-1), with the carry out of bit 0 equal to g[0]. The prefix tree must agree with this ripple recurrence in every column. A group propagate may be 1 only if the column's own propagate bit is 1.
- R4: Parameter `TREE` selects `TREE_SPARSE` (value 0) or `TREE_DENSE` (value 1). For the same operand stream, both settings give bit-identical `sum_o` and `carry_o`.
- R5: Sum bit 0 equals A[0] XOR B[0], since there is no carry-in. Sum bit i equals A[i] XOR B[i] XOR the carry out of bit i-1. Example: carries ripple across the full width when a single 1 is added to all ones.
- R6: A pair applied before rising edge k appears on the outputs after edge k + 1 + IN_XTRA + OUT_XTRA, where IN_XTRA and OUT_XTRA each range from 0 to 2. A new pair is accepted on every cycle.
- R7: While `rst_ni` is low, every register clears at once and both outputs read 0. After `rst_ni` rises, the internal reset stays asserted for two more rising edges, so the outputs remain 0 for at least the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_a_i | input | W | First operand |
| op_b_i | input | W | Second operand |
| sum_o | output | W | Registered sum, modulo 2^W |
| carry_o | output | 1 | Registered carry-out |

## Verification
Several properties are checked on every cycle:

- the arithmetic identity between the captured operands and the combinational sum and carry;
- carry implications from the top operand bits;
- the equivalence of the prefix tree's final carries with the ripple recurrence in every column;
- the zero outputs during reset.

The bench alone can show that the exact latency holds for each register setting, since it depends on depth counts. It also shows that the sparse and dense builds agree on the same stream, and that carries behave correctly at the boundaries, such as full-width carry runs and all-ones overflow.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  typedef enum logic [0:0] {
    TREE_SPARSE = 1'b0,
    TREE_DENSE  = 1'b1
  } tree_e;
endpackage

// File: rtl/ppa_rst_sync.sv
module ppa_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_d;
  logic [1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/ppa_pipe.sv
module ppa_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_d [DEPTH];
  logic [W-1:0] stg_q [DEPTH];

  always_comb begin
    stg_d[0] = d_i;
    for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/ppa_prefix_net.sv
module ppa_prefix_net
  import ppa_pkg::*;
#(
  parameter int    W    = 128,
  parameter tree_e TREE = TREE_SPARSE
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  output logic [W-1:0] grp_g_o
);
  localparam int LVL = $clog2(W);

  logic [LVL:0][W-1:0]   gl;
  logic [LVL-1:0][W-1:0] pl;

  assign gl[0] = g_i;
  assign pl[0] = p_i;

  for (genvar j = 0; j < LVL; j++) begin : g_lvl
    localparam int DIST = 1 << j;
    for (genvar i = 0; i < W; i++) begin : g_col
      if (TREE == TREE_SPARSE) begin : g_sparse
        if (((i >> j) & 1) == 1) begin : g_cell
          localparam int PART = ((i >> j) << j) - 1;
          assign gl[j+1][i] = gl[j][i] | (pl[j][i] & gl[j][PART]);
          if (j + 1 < LVL) begin : g_pout
            assign pl[j+1][i] = pl[j][i] & pl[j][PART];
          end
        end else begin : g_pass
          assign gl[j+1][i] = gl[j][i];
          if (j + 1 < LVL) begin : g_pout
            assign pl[j+1][i] = pl[j][i];
          end
        end
      end else begin : g_dense
        if (i >= DIST) begin : g_cell
          localparam int PART = i - DIST;
          assign gl[j+1][i] = gl[j][i] | (pl[j][i] & gl[j][PART]);
          if (j + 1 < LVL) begin : g_pout
            assign pl[j+1][i] = pl[j][i] & pl[j][PART];
          end
        end else begin : g_pass
          assign gl[j+1][i] = gl[j][i];
          if (j + 1 < LVL) begin : g_pout
            assign pl[j+1][i] = pl[j][i];
          end
        end
      end
    end
  end

  assign grp_g_o = gl[LVL];

  // R3: final tree carries match the ripple recurrence column by column;
  // a group propagate can never be set where the column's own bit does not propagate.
  always_comb begin
    if (!$isunknown({p_i, g_i})) begin
      a_r3_bit0_carry: assert (gl[LVL][0] == g_i[0]);
      for (int i = 1; i < W; i++) begin
        a_r3_ripple_equiv: assert (gl[LVL][i] == (g_i[i] | (p_i[i] & gl[LVL][i-1])));
      end
      for (int j = 0; j < LVL; j++) begin
        for (int i = 0; i < W; i++) begin
          a_r3_prop_subset: assert (!pl[j][i] || p_i[i]);
        end
      end
    end
  end
endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
  import ppa_pkg::*;
#(
  parameter int    W        = 128,
  parameter tree_e TREE     = TREE_SPARSE,
  parameter int    IN_XTRA  = 0,
  parameter int    OUT_XTRA = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int IN_DEPTH  = 1 + IN_XTRA;
  localparam int OUT_DEPTH = 1 + OUT_XTRA;

  logic           rst_int_n;
  logic [2*W-1:0] ops_q;
  logic [W-1:0]   a_q, b_q;
  logic [W-1:0]   prop, gen, grp_g;
  logic [W-1:0]   sum_c;
  logic           co_c;
  logic [W:0]     res_q;

  ppa_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  ppa_pipe #(.W(2*W), .DEPTH(IN_DEPTH)) u_in_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    ({op_a_i, op_b_i}),
    .q_o    (ops_q)
  );

  assign a_q  = ops_q[2*W-1:W];
  assign b_q  = ops_q[W-1:0];
  assign prop = a_q ^ b_q;
  assign gen  = a_q & b_q;

  ppa_prefix_net #(.W(W), .TREE(TREE)) u_prefix (
    .p_i     (prop),
    .g_i     (gen),
    .grp_g_o (grp_g)
  );

  assign sum_c = prop ^ {grp_g[W-2:0], 1'b0};
  assign co_c  = grp_g[W-1];

  ppa_pipe #(.W(W+1), .DEPTH(OUT_DEPTH)) u_out_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    ({co_c, sum_c}),
    .q_o    (res_q)
  );

  assign sum_o   = res_q[W-1:0];
  assign carry_o = res_q[W];

  // R1 / R5: the structural sum agrees with arithmetic addition of the captured operands
  a_r1_sum_matches: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    {co_c, sum_c} == ({1'b0, a_q} + {1'b0, b_q}));

  // R2: both top bits set forces a carry; a carry needs at least one top bit
  a_r2_carry_forced: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (a_q[W-1] & b_q[W-1]) |-> co_c);
  a_r2_carry_needs_top: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    co_c |-> (a_q[W-1] | b_q[W-1]));

  // R7: outputs are zero while the internal reset is held
  a_r7_reset_clear: assert property (@(negedge clk_i)
    !rst_int_n |-> (sum_o == '0 && carry_o == 1'b0));
endmodule

// File: tb/ppa_adder_tb.sv
`timescale 1ns/1ps
module ppa_adder_tb;
  import ppa_pkg::*;

  localparam int W    = 128;
  localparam int LAT0 = 2;
  localparam int LAT1 = 2 + 1 + 2;
  localparam int HIST = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a, op_b;
  logic [W-1:0] s0, s1;
  logic         c0, c1;

  int n_chk  = 0;
  int n_fail = 0;
  logic         armed = 1'b0;
  logic [W:0]   hist [HIST];
  logic [63:0]  rng = 64'h1234_5678_9ABC_DEF1;

  always #4 clk = ~clk;

  ppa_adder #(.W(W), .TREE(TREE_SPARSE), .IN_XTRA(0), .OUT_XTRA(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(op_a), .op_b_i(op_b), .sum_o(s0), .carry_o(c0));

  ppa_adder #(.W(W), .TREE(TREE_DENSE), .IN_XTRA(1), .OUT_XTRA(2)) u_dut_dense (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(op_a), .op_b_i(op_b), .sum_o(s1), .carry_o(c1));

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lfsr_next(input logic [63:0] x);
    return (x >> 1) ^ (x[0] ? 64'hD800_0000_0000_0000 : 64'h0);
  endfunction

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] w;
    for (int k = 0; k < W / 64; k++) begin
      rng = lfsr_next(rng);
      w[k*64 +: 64] = rng;
    end
    return w;
  endfunction

  // one cycle: check both builds against the delayed reference, then drive the next pair
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    if (armed) begin
      check({tag, " sparse"}, {c0, s0}, hist[LAT0-1]);
      check({tag, " dense"},  {c1, s1}, hist[LAT1-1]);
    end
    for (int k = HIST - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = {1'b0, a} + {1'b0, b};
    op_a = a;
    op_b = b;
  endtask

  task automatic clear_hist();
    for (int k = 0; k < HIST; k++) hist[k] = '0;
  endtask

  task automatic warm_up();
    armed = 1'b0;
    clear_hist();
    for (int k = 0; k < 10; k++) step('0, '0, "warm");
    armed = 1'b1;
  endtask

  // R7: reset holds outputs at zero even with operands applied; sync holds past release
  task automatic t_reset_hold();
    rst_n = 1'b0;
    op_a = {W{1'b1}};
    op_b = {W{1'b1}};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 reset sparse", {c0, s0}, '0);
      check("R7 reset dense",  {c1, s1}, '0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after release sparse", {c0, s0}, '0);
    check("R7 after release dense",  {c1, s1}, '0);
    warm_up();
  endtask

  task automatic t_directed();
    step({{(W/2){1'b0}}, {(W/2){1'b1}}}, {{(W/2){1'b1}}, {(W/2){1'b0}}}, "R1 halves");
    step({(W/4){4'hA}}, {(W/4){4'h5}}, "R1 nibbles");
    step({W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, "R2 overflow to zero");
    step({W{1'b1}}, {W{1'b1}}, "R2 ones plus ones");
    step({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, "R2 top bits only");
    step({{(W-1){1'b1}}, 1'b0}, {{(W-1){1'b0}}, 1'b1}, "R5 no carry all propagate");
    step({(W/2){2'b01}}, {(W/2){2'b01}}, "R3 alternating generates");
    step({W{1'b0}}, {W{1'b0}}, "R1 zero");
    step({(W/8){8'h0F}}, {(W/8){8'h01}}, "R3 byte carry runs");
    for (int k = 0; k < LAT1; k++) step('0, '0, "R1 drain");
  endtask

  // R6: an isolated pair emerges exactly at its latency, flanked by zeros
  task automatic t_latency();
    for (int k = 0; k < 4; k++) step('0, '0, "R6 idle");
    step({W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, "R6 pulse");
    for (int k = 0; k < LAT1 + 1; k++) step('0, '0, "R6 trail");
  endtask

  task automatic t_random(input int n);
    for (int k = 0; k < n; k++) step(rand_word(), rand_word(), "R4 random");
    for (int k = 0; k < LAT1; k++) step('0, '0, "R4 drain");
  endtask

  // R7: asynchronous reset mid-stream clears outputs without a clock edge
  task automatic t_midrun_reset();
    for (int k = 0; k < 5; k++) step(rand_word(), rand_word(), "R1 pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 async clear sparse", {c0, s0}, '0);
    check("R7 async clear dense",  {c1, s1}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    warm_up();
    t_random(40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_a = '0;
    op_b = '0;
    clear_hist();
    t_reset_hold();
    t_directed();
    t_latency();
    t_random(300);
    t_midrun_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule